// File: doc/BRIEF.md
# Serial External Memory Word Stepper

This block carries one data word between a processing core and an external memory that has an 8-bit data bus and a 20-bit byte address. A transfer spends one memory access on each clock cycle. When a read or write is started, the block forms a byte address from an offset input and a circular base register. It then walks that address upward one location per cycle. On a read it assembles the word from the returned pieces. On a write it emits the word one piece at a time.

Three configuration inputs shape a transfer. The first picks the word size, 24 or 16 bits. The second picks the bus granularity: a whole byte per access, or only the low nibble. The third picks the memory size, which fixes how many address bits survive. The base register counts down once per sample-sync pulse, so a fixed offset walks backwards through memory from one sample to the next. That is how a delay line is built on top of this block. Deciding when to start a transfer is left to the surrounding core.

Top module: `xm_serial_stepper`

## Requirements
- R1: On an accepted start, the first access address is (offset + base), taken modulo 2^20. It is then shifted left by 2 for a 24-bit word (cfg_word24=1) or by 1 for a 16-bit word, plus one more place when cfg_nibble=1.
- R2: The start address is then cut to 16 bits (cfg_msize=0), 18 bits (cfg_msize=1) or 20 bits (cfg_msize=2 or 3).
- R3: In byte mode (cfg_nibble=0), step k of a transfer carries word bits [8k+7:8k] on the data bus. A 24-bit word takes 3 steps and a 16-bit word takes 2.
- R4: In nibble mode, step k carries word bits [4k+3:4k] on data bits [3:0]. The upper four read-data bits are ignored and the upper four write-data bits are driven 0. A 24-bit word takes 6 steps and a 16-bit word takes 4.
- R5: When a 16-bit read completes, rd_word[23:16] is 0, whatever an earlier transfer left there.
- R6: During a transfer, exactly one of mem_rd / mem_wr is high in each step, matching the busy flag. mem_addr rises by one from each step to the next.
- R7: In the cycle after the last step, the busy flag is low, mem_addr is 0, and both strobes are low.
- R8: The base register resets to 0. Each cycle with sample_sync high decrements it modulo 2^19, including while a transfer is running.
- R9: A start on either input while either busy flag is high is ignored. If start_rd and start_wr are both high in the same idle cycle, the read is performed and the write is dropped.
- R10: The configuration, offset and write word are captured at the accepted start. Changing them during the transfer does not alter its addresses or data.
- R11: Read data on mem_rdata is taken in the same cycle in which its address is on mem_addr.
- R12: After reset, both busy flags, both strobes, mem_addr and rd_word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_sync | input | 1 | Sample-sync pulse, decrements the base register |
| start_rd | input | 1 | Request a read transfer |
| start_wr | input | 1 | Request a write transfer |
| cfg_word24 | input | 1 | 1: 24-bit word, 0: 16-bit word |
| cfg_nibble | input | 1 | 1: nibble-wide bus, 0: byte-wide bus |
| cfg_msize | input | 2 | Memory size: 0 64K, 1 256K, 2/3 1M |
| xfer_offset | input | 20 | Offset added to the base register |
| wr_word | input | 24 | Word to be written |
| rd_word | output | 24 | Assembled read word |
| rd_busy | output | 1 | Read transfer in progress |
| wr_busy | output | 1 | Write transfer in progress |
| mem_addr | output | 20 | External memory byte address |
| mem_rdata | input | 8 | External memory read data |
| mem_rd | output | 1 | Read strobe for the current step |
| mem_wr | output | 1 | Write strobe for the current step |
| mem_wdata | output | 8 | External memory write data |

## Verification
The hardest case to reach from the ports is a mid-transfer disturbance: in a single step, the configuration, offset and write word all change, a new start is requested, and a sample-sync arrives. The bench does this on purpose at the second step of selected transfers, then checks that the addresses and data of the running transfer keep to the captured settings. A second corner is a base register that has wrapped below zero, so that the offset sum overflows out of the masked range. The bench reaches it by issuing a sync straight after reset, which puts the base at its maximum. A full sweep over word size, granularity, memory size and several offsets then runs with syncs in between.

// File: rtl/xm_pkg.sv
package xm_pkg;

    localparam int XM_ADDR_W = 20;
    localparam int XM_BASE_W = 19;
    localparam int XM_WORD_W = 24;
    localparam int XM_HALF_W = 16;
    localparam int XM_BUS_W  = 8;
    localparam int XM_NIB_W  = 4;
    localparam int XM_LANE_W = 5;

    typedef struct packed {
        logic       word24;
        logic       nibble;
        logic [1:0] msize;
    } xm_cfg_t;

    typedef enum logic [1:0] {
        XM_IDLE  = 2'd0,
        XM_READ  = 2'd1,
        XM_WRITE = 2'd2
    } xm_state_t;

    // Address scaling: 2 for long words, 1 for short, plus 1 on a nibble bus
    function automatic logic [1:0] xm_scale(input xm_cfg_t c);
        return (c.word24 ? 2'd2 : 2'd1) + {1'b0, c.nibble};
    endfunction

    function automatic logic [XM_LANE_W-1:0] xm_piece(input xm_cfg_t c);
        return c.nibble ? XM_LANE_W'(XM_NIB_W) : XM_LANE_W'(XM_BUS_W);
    endfunction

    // Bit offset of the piece handled at this address
    function automatic logic [XM_LANE_W-1:0] xm_lane(input xm_cfg_t c, input logic [2:0] low);
        logic [2:0] sel;
        sel = low & ((3'd1 << xm_scale(c)) - 3'd1);
        return c.nibble ? {sel, 2'b00} : {sel[1:0], 3'b000};
    endfunction

    // Offset of the final piece of a word
    function automatic logic [XM_LANE_W-1:0] xm_last(input xm_cfg_t c);
        return (c.word24 ? XM_LANE_W'(XM_WORD_W) : XM_LANE_W'(XM_HALF_W)) - xm_piece(c);
    endfunction

endpackage

// File: rtl/xm_base_ctr.sv
module xm_base_ctr #(
    parameter int BASE_W = xm_pkg::XM_BASE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_i,
    output logic [BASE_W-1:0] base_o
);
    // R8: circular base, counts down once per sample sync
    always_ff @(posedge clk) begin
        if (rst)
            base_o <= '0;
        else if (sync_i)
            base_o <= base_o - 1'b1;
    end
endmodule

// File: rtl/xm_start_addr.sv
module xm_start_addr
    import xm_pkg::*;
#(
    parameter int ADDR_W = XM_ADDR_W,
    parameter int BASE_W = XM_BASE_W
) (
    input  xm_cfg_t           cfg_i,
    input  logic [ADDR_W-1:0] ofs_i,
    input  logic [BASE_W-1:0] base_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int SMALL_W = ADDR_W - 4;
    localparam int MID_W   = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] MASK_S = {{(ADDR_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};
    localparam logic [ADDR_W-1:0] MASK_M = {{(ADDR_W-MID_W){1'b0}}, {MID_W{1'b1}}};
    localparam logic [ADDR_W-1:0] MASK_L = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] scaled;

    always_comb begin
        // R1: offset plus base, scaled to a byte address
        sum    = ofs_i + {{(ADDR_W-BASE_W){1'b0}}, base_i};
        scaled = sum << xm_scale(cfg_i);
        // R2: memory-size window
        unique case (cfg_i.msize)
            2'd0:    addr_o = scaled & MASK_S;
            2'd1:    addr_o = scaled & MASK_M;
            default: addr_o = scaled & MASK_L;
        endcase
    end
endmodule

// File: rtl/xm_step_ctrl.sv
module xm_step_ctrl
    import xm_pkg::*;
#(
    parameter int ADDR_W = XM_ADDR_W,
    parameter int WORD_W = XM_WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_rd_i,
    input  logic                 start_wr_i,
    input  xm_cfg_t              cfg_i,
    input  logic [ADDR_W-1:0]    start_addr_i,
    input  logic [WORD_W-1:0]    wr_word_i,
    output xm_state_t            state_o,
    output logic [ADDR_W-1:0]    adr_o,
    output xm_cfg_t              cfg_o,
    output logic [WORD_W-1:0]    wr_q_o,
    output logic [XM_LANE_W-1:0] lane_o,
    output logic                 last_o
);
    always_comb begin
        lane_o = xm_lane(cfg_o, adr_o[2:0]);
        last_o = (state_o != XM_IDLE) && (lane_o == xm_last(cfg_o));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= XM_IDLE;
            adr_o   <= '0;
            cfg_o   <= '0;
            wr_q_o  <= '0;
        end else begin
            unique case (state_o)
                XM_IDLE: begin
                    // R9: read wins over write; starts only taken when idle
                    // R10: settings captured here
                    if (start_rd_i) begin
                        state_o <= XM_READ;
                        adr_o   <= start_addr_i;
                        cfg_o   <= cfg_i;
                    end else if (start_wr_i) begin
                        state_o <= XM_WRITE;
                        adr_o   <= start_addr_i;
                        cfg_o   <= cfg_i;
                        wr_q_o  <= wr_word_i;
                    end
                end
                default: begin
                    // R6 / R7: advance or finish
                    if (last_o) begin
                        state_o <= XM_IDLE;
                        adr_o   <= '0;
                    end else begin
                        adr_o   <= adr_o + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/xm_read_pack.sv
module xm_read_pack
    import xm_pkg::*;
#(
    parameter int WORD_W = XM_WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_i,
    input  logic                 last_i,
    input  xm_cfg_t              cfg_i,
    input  logic [XM_LANE_W-1:0] lane_i,
    input  logic [XM_BUS_W-1:0]  rdata_i,
    output logic [WORD_W-1:0]    word_o
);
    logic [WORD_W-1:0] ext;
    logic [WORD_W-1:0] pmask;
    logic [WORD_W-1:0] nxt;

    always_comb begin
        ext = '0;
        ext[XM_BUS_W-1:0] = rdata_i;
        if (cfg_i.nibble) begin
            // R4: upper data bits ignored on a nibble bus
            ext[XM_BUS_W-1:XM_NIB_W] = '0;
            pmask = {{(WORD_W-XM_NIB_W){1'b0}}, {XM_NIB_W{1'b1}}};
        end else begin
            pmask = {{(WORD_W-XM_BUS_W){1'b0}}, {XM_BUS_W{1'b1}}};
        end
        pmask = pmask << lane_i;
        ext   = ext << lane_i;
        nxt   = (word_o & ~pmask) | (ext & pmask);
        // R5: short word cleared above its width on completion
        if (last_i && !cfg_i.word24)
            nxt[WORD_W-1:XM_HALF_W] = '0;
    end

    // R11: data sampled in the same step its address is driven
    always_ff @(posedge clk) begin
        if (rst)
            word_o <= '0;
        else if (step_i)
            word_o <= nxt;
    end
endmodule

// File: rtl/xm_serial_stepper.sv
module xm_serial_stepper
    import xm_pkg::*;
#(
    parameter int ADDR_W = XM_ADDR_W,
    parameter int BASE_W = XM_BASE_W,
    parameter int WORD_W = XM_WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_sync,
    input  logic                start_rd,
    input  logic                start_wr,
    input  logic                cfg_word24,
    input  logic                cfg_nibble,
    input  logic [1:0]          cfg_msize,
    input  logic [ADDR_W-1:0]   xfer_offset,
    input  logic [WORD_W-1:0]   wr_word,
    output logic [WORD_W-1:0]   rd_word,
    output logic                rd_busy,
    output logic                wr_busy,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [XM_BUS_W-1:0] mem_rdata,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [XM_BUS_W-1:0] mem_wdata
);
    xm_cfg_t              live_cfg;
    xm_cfg_t              act_cfg;
    logic                 act_nibble;
    logic [BASE_W-1:0]    base;
    logic [ADDR_W-1:0]    start_addr;
    xm_state_t            state;
    logic [WORD_W-1:0]    wr_q;
    logic [WORD_W-1:0]    wshift;
    logic [XM_LANE_W-1:0] lane;
    logic                 last;

    assign live_cfg   = '{word24: cfg_word24, nibble: cfg_nibble, msize: cfg_msize};
    assign act_nibble = act_cfg.nibble;

    xm_base_ctr #(.BASE_W(BASE_W)) u_base (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sample_sync),
        .base_o (base)
    );

    xm_start_addr #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_addr (
        .cfg_i  (live_cfg),
        .ofs_i  (xfer_offset),
        .base_i (base),
        .addr_o (start_addr)
    );

    xm_step_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_rd_i   (start_rd),
        .start_wr_i   (start_wr),
        .cfg_i        (live_cfg),
        .start_addr_i (start_addr),
        .wr_word_i    (wr_word),
        .state_o      (state),
        .adr_o        (mem_addr),
        .cfg_o        (act_cfg),
        .wr_q_o       (wr_q),
        .lane_o       (lane),
        .last_o       (last)
    );

    assign rd_busy = (state == XM_READ);
    assign wr_busy = (state == XM_WRITE);
    assign mem_rd  = rd_busy;
    assign mem_wr  = wr_busy;

    xm_read_pack #(.WORD_W(WORD_W)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .step_i  (rd_busy),
        .last_i  (last),
        .cfg_i   (act_cfg),
        .lane_i  (lane),
        .rdata_i (mem_rdata),
        .word_o  (rd_word)
    );

    // R3 / R4: piece selection for writes
    always_comb begin
        wshift = wr_q >> lane;
        if (!wr_busy)
            mem_wdata = '0;
        else if (act_cfg.nibble)
            mem_wdata = {{(XM_BUS_W-XM_NIB_W){1'b0}}, wshift[XM_NIB_W-1:0]};
        else
            mem_wdata = wshift[XM_BUS_W-1:0];
    end
endmodule

// File: rtl/xm_stepper_chk.sv
module xm_stepper_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              start_rd,
    input logic              start_wr,
    input logic              rd_busy,
    input logic              wr_busy,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              act_nibble
);
    logic [2:0] run_len;
    logic       busy;

    assign busy = rd_busy || wr_busy;

    always_ff @(posedge clk) begin
        if (rst)
            run_len <= '0;
        else if (busy)
            run_len <= run_len + 1'b1;
        else
            run_len <= '0;
    end

    a_r9_one_direction: assert property (@(posedge clk) disable iff (rst)
        !(rd_busy && wr_busy));

    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        ((rd_busy && $past(rd_busy)) || (wr_busy && $past(wr_busy)))
            |-> mem_addr == $past(mem_addr) + 1'b1);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_addr == '0 && !mem_rd && !mem_wr));

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (rd_busy && start_wr) |=> !wr_busy);

    a_r4_nibble_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && act_nibble) |-> mem_wdata[7:4] == 4'h0);

    a_r3_run_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> run_len < 3'd6);

    a_r6_strobe_match: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_rd, mem_wr}) == $countones({rd_busy, wr_busy}));
endmodule

bind xm_serial_stepper xm_stepper_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_rd   (start_rd),
    .start_wr   (start_wr),
    .rd_busy    (rd_busy),
    .wr_busy    (wr_busy),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .act_nibble (act_nibble)
);

// File: tb/tb_xm_serial_stepper.sv
module tb_xm_serial_stepper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_sync = 1'b0;
    logic        start_rd = 1'b0;
    logic        start_wr = 1'b0;
    logic        cfg_word24 = 1'b0;
    logic        cfg_nibble = 1'b0;
    logic [1:0]  cfg_msize = 2'd0;
    logic [19:0] xfer_offset = '0;
    logic [23:0] wr_word = '0;
    logic [23:0] rd_word;
    logic        rd_busy, wr_busy, mem_rd, mem_wr;
    logic [19:0] mem_addr;
    logic [7:0]  mem_rdata, mem_wdata;

    int checks = 0;
    int failures = 0;
    int base_m = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'hA5;
    endfunction

    // R11: combinational memory model
    assign mem_rdata = mem_f(mem_addr);

    xm_serial_stepper dut (
        .clk(clk), .rst(rst), .sample_sync(sample_sync),
        .start_rd(start_rd), .start_wr(start_wr),
        .cfg_word24(cfg_word24), .cfg_nibble(cfg_nibble), .cfg_msize(cfg_msize),
        .xfer_offset(xfer_offset), .wr_word(wr_word), .rd_word(rd_word),
        .rd_busy(rd_busy), .wr_busy(wr_busy), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic do_sync();
        @(negedge clk);
        sample_sync = 1'b1;
        base_m = (base_m - 1) & 32'h7FFFF;
        @(negedge clk);
        sample_sync = 1'b0;
    endtask

    task automatic xfer(input bit is_wr, input bit w24, input bit nib, input logic [1:0] ms,
                        input logic [19:0] ofs, input bit disturb, input bit both);
        int sh, n, mask, a0;
        logic [23:0] wd, expw;
        logic [7:0]  piece;
        bit ok_strb, ok_addr, ok_data;
        logic [31:0] bad_a_act, bad_a_exp, bad_d_act, bad_d_exp;
        sh   = (w24 ? 2 : 1) + (nib ? 1 : 0);
        n    = (w24 ? 3 : 2) * (nib ? 2 : 1);
        mask = (ms == 2'd0) ? 32'hFFFF : (ms == 2'd1) ? 32'h3FFFF : 32'hFFFFF;
        a0   = ((((int'(ofs) + base_m) & 32'hFFFFF) << sh) & mask);
        wd   = {ofs[11:0], ~ofs[11:0]} ^ 24'h5A3C96 ^ {8'h00, 8'(base_m), 8'h00};
        @(negedge clk);
        cfg_word24 = w24; cfg_nibble = nib; cfg_msize = ms;
        xfer_offset = ofs; wr_word = wd;
        start_rd = !is_wr || both;
        start_wr = is_wr || both;
        @(negedge clk);
        start_rd = 1'b0; start_wr = 1'b0;
        expw = '0;
        ok_strb = 1'b1; ok_addr = 1'b1; ok_data = 1'b1;
        bad_a_act = 0; bad_a_exp = 0; bad_d_act = 0; bad_d_exp = 0;
        for (int k = 0; k < n; k++) begin
            start_rd = 1'b0; start_wr = 1'b0; sample_sync = 1'b0;
            if (is_wr) begin
                if (!(wr_busy && !rd_busy && mem_wr && !mem_rd)) ok_strb = 1'b0;
            end else begin
                if (!(rd_busy && !wr_busy && mem_rd && !mem_wr)) ok_strb = 1'b0;
            end
            if (mem_addr != 20'(a0 + k)) begin
                ok_addr = 1'b0; bad_a_act = 32'(mem_addr); bad_a_exp = 32'(a0 + k);
            end
            if (is_wr) begin
                piece = nib ? {4'h0, wd[4*k +: 4]} : wd[8*k +: 8];
                if (mem_wdata != piece) begin
                    ok_data = 1'b0; bad_d_act = 32'(mem_wdata); bad_d_exp = 32'(piece);
                end
            end else begin
                piece = mem_f(20'(a0 + k));
                if (nib) expw[4*k +: 4] = piece[3:0];
                else     expw[8*k +: 8] = piece;
            end
            if (disturb && k == 1) begin
                // R10: settings disturbed mid-transfer; R9: new starts; R8: sync
                cfg_word24 = !w24; cfg_nibble = !nib; cfg_msize = ~ms;
                xfer_offset = ~ofs; wr_word = ~wd;
                start_rd = 1'b1; start_wr = 1'b1;
                sample_sync = 1'b1;
                base_m = (base_m - 1) & 32'h7FFFF;
            end
            @(negedge clk);
        end
        start_rd = 1'b0; start_wr = 1'b0; sample_sync = 1'b0;
        chk(ok_strb, disturb ? "R6 R9 strobes" : "R6 strobes", 32'(ok_strb), 1);
        chk(ok_addr, disturb ? "R1 R2 R6 R10 address" : "R1 R2 R6 address", bad_a_act, bad_a_exp);
        if (is_wr)
            chk(ok_data, nib ? "R4 write piece" : "R3 write piece", bad_d_act, bad_d_exp);
        else
            chk(rd_word == expw,
                !w24 ? "R5 R11 read word" : (nib ? "R4 R11 read word" : "R3 R11 read word"),
                32'(rd_word), 32'(expw));
        chk(!rd_busy && !wr_busy && mem_addr == '0 && !mem_rd && !mem_wr,
            "R7 R9 idle after completion", {rd_busy, wr_busy, mem_rd, mem_wr, 8'h0, mem_addr}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk(!rd_busy && !wr_busy && !mem_rd && !mem_wr && mem_addr == '0 && rd_word == '0,
            "R12 reset state", {rd_busy, wr_busy, mem_rd, mem_wr, 4'h0, rd_word}, 0);

        // R8: base wraps below zero; offset 1 then overflows out of the window
        do_sync();
        xfer(1'b0, 1'b1, 1'b0, 2'd2, 20'h00001, 1'b0, 1'b0);
        chk(base_m == 32'h7FFFF, "R8 base wrap tracked", 32'(base_m), 32'h7FFFF);
        xfer(1'b1, 1'b1, 1'b1, 2'd2, 20'hFFFFF, 1'b0, 1'b0);

        // Sweep of all configurations
        for (int w = 0; w < 2; w++)
            for (int nb = 0; nb < 2; nb++)
                for (int ms = 0; ms < 4; ms++) begin
                    do_sync();
                    for (int o = 0; o < 3; o++) begin
                        logic [19:0] ofs;
                        ofs = (o == 0) ? 20'h00000 : (o == 1) ? 20'h12345 : 20'hFEDCB;
                        xfer(1'b0, w[0], nb[0], 2'(ms), ofs, 1'b0, 1'b0);
                        xfer(1'b1, w[0], nb[0], 2'(ms), ofs ^ 20'h0A5A5, 1'b0, 1'b0);
                    end
                end

        // R9 / R10: disturbance during each mode
        for (int w = 0; w < 2; w++)
            for (int nb = 0; nb < 2; nb++) begin
                xfer(1'b0, w[0], nb[0], 2'd1, 20'h3C3C3, 1'b1, 1'b0);
                xfer(1'b1, w[0], nb[0], 2'd2, 20'h0F0F1, 1'b1, 1'b0);
            end

        // R9: both starts in one idle cycle, read wins
        xfer(1'b0, 1'b1, 1'b0, 2'd2, 20'h55555, 1'b0, 1'b1);
        xfer(1'b0, 1'b0, 1'b1, 2'd0, 20'h0ABCD, 1'b0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule